// File: doc/BRIEF.md
# Processor Reset and Bus-Error Supervisor

This block gathers every fault condition on a processor board and turns it into three registered outputs. The first is a reset for the main processor. The second is a bus-error signal that stops the processor's current access. The third is a reset pulse toward the companion network controller. All inputs are taken to be synchronous to `clk`. The analog supply comparator lives outside the block; only its digital flag arrives here.

The processor is held in reset in three cases: while power is not yet good, while the supply-low flag is raised, and while the network controller reports that the processor has lost sanity. After the last such source clears, reset is held for a further fixed number of clocks, so a supply dip never lets the processor run before the rail has recovered.

A bus error is raised in three cases: a protection violation from the memory protection unit, an access left unacknowledged for too long (the addressed device is absent), or the same peer sanity flag. The processor can also reset the network controller with a single request cycle, which produces a pulse of fixed width. A two-bit cause register keeps the source of the most recent reset. A processor reset does not clear it, so software can read it after restart.

Top module: `rsup_top`

## Requirements
- R1: While `pwr_ok` is low, `cpu_rst` is high from the clock edge after it is sampled low, and `rst_cause` records power-up (code 0).
- R2: While `vdd_low` is high, `cpu_rst` is high from the clock edge after it is sampled high, and `rst_cause` records supply-low (code 1).
- R3: After the last clock edge at which any reset source (`rst`, low `pwr_ok`, `vdd_low`, `nc_insane`) is sampled active, `cpu_rst` stays high for exactly HOLD_CYC more sampled cycles and then falls.
- R4: While `nc_insane` is high, both `cpu_rst` and `cpu_berr` are high from the next clock edge, and `rst_cause` records peer-insane (code 2).
- R5: Each cycle in which `prot_viol` is sampled high makes `cpu_berr` high in the following cycle, so a pulse of W cycles gives a bus error of W cycles.
- R6: When `as_strobe` is sampled high with `dtack` low on ACK_TMO consecutive edges, `cpu_berr` is high after the ACK_TMO-th edge and stays high while that condition holds. A `dtack` sampled high restarts the count, so an access acknowledged within ACK_TMO-1 edges never raises a bus error.
- R7: A request cycle on `nc_rst_req` makes `nc_rst` high for exactly NC_PULSE cycles from the next edge. A new request during the pulse restarts the full width.
- R8: When several reset sources are active in the same cycle, the cause recorded is the one of highest priority: power-up, then supply-low, then peer-insane. `rst_cause` does not change in any cycle with no reset source active, including the release of `cpu_rst`, bus errors and controller-reset requests.
- R9: While `rst` is high, `cpu_rst` is high, `cpu_berr` and `nc_rst` are low, and `rst_cause` is power-up (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high board reset |
| pwr_ok | input | 1 | Power-good, high when the board supply is valid |
| vdd_low | input | 1 | Supply-low comparator flag |
| prot_viol | input | 1 | Protection violation pulse from memory management |
| as_strobe | input | 1 | Processor address strobe, high during an access |
| dtack | input | 1 | Data-transfer acknowledge from the addressed device |
| nc_insane | input | 1 | Network controller declares the processor insane |
| nc_rst_req | input | 1 | Single-cycle software request to reset the network controller |
| cpu_rst | output | 1 | Processor reset |
| cpu_berr | output | 1 | Processor bus error |
| nc_rst | output | 1 | Network controller reset pulse |
| rst_cause | output | 2 | Source of the most recent reset: 0 power-up, 1 supply-low, 2 peer-insane |

## Verification
The hold time after release is measured for each of the three reset sources, with each source held for several lengths. This separates a counter that starts when the source clears from one that starts when it is first seen. The access timeout is swept over every unacknowledged length around the limit, and over every acknowledge delay below it, which exposes off-by-one errors in the limit and a count that is not restarted. Protection pulses of several widths, overlapping sources and retriggered controller resets test the bus-error path, the cause priority and the pulse reload.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef enum logic [1:0] {
    CAUSE_PWRUP = 2'd0,
    CAUSE_BROWN = 2'd1,
    CAUSE_PEER  = 2'd2
  } cause_e;
endpackage

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
  parameter int HOLD = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  output logic hold_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;
  logic          hold_q;
  logic          src_all;

  assign src_all = rst | src;

  // Counter reloads while any source is present and drains once all are gone.
  always_ff @(posedge clk) begin
    if (src_all) begin
      cnt    <= CW'(HOLD);
      hold_q <= 1'b1;
    end else if (cnt != '0) begin
      cnt    <= cnt - CW'(1);
      hold_q <= 1'b1;
    end else begin
      hold_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;

  AST_HOLD_NO_EARLY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> !$past(src_all)); // R3
  AST_HOLD_SRC_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    src |=> hold_q); // R3
endmodule

// File: rtl/rsup_timeout.sv
module rsup_timeout #(
  parameter int TMO = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic ack,
  output logic late_o
);
  localparam int CW  = (TMO > 2) ? $clog2(TMO) : 1;
  localparam int LIM = TMO - 1;

  logic [CW-1:0] cnt;

  // Count unacknowledged strobe edges, saturating at the limit.
  always_ff @(posedge clk) begin
    if (rst || !strobe || ack) begin
      cnt <= '0;
    end else if (cnt != CW'(LIM)) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign late_o = strobe & ~ack & (cnt == CW'(LIM));

  AST_ACK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    ack |=> (cnt == '0)); // R6
  AST_IDLE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (cnt == '0)); // R6
endmodule

// File: rtl/rsup_pulse.sv
module rsup_pulse #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse_o
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_n;
  logic          q;

  always_comb begin
    if (trig)             cnt_n = CW'(WIDTH);
    else if (cnt != '0)   cnt_n = cnt - CW'(1);
    else                  cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      cnt <= cnt_n;
      q   <= (cnt_n != '0);
    end
  end

  assign pulse_o = q;

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
    trig |=> q); // R7
  AST_PULSE_NO_CUT: assert property (@(posedge clk) disable iff (rst)
    $fell(q) |-> !$past(trig)); // R7
endmodule

// File: rtl/rsup_top.sv
module rsup_top
  import rsup_pkg::*;
#(
  parameter int HOLD_CYC = 1024,
  parameter int ACK_TMO  = 64,
  parameter int NC_PULSE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_ok,
  input  logic       vdd_low,
  input  logic       prot_viol,
  input  logic       as_strobe,
  input  logic       dtack,
  input  logic       nc_insane,
  input  logic       nc_rst_req,
  output logic       cpu_rst,
  output logic       cpu_berr,
  output logic       nc_rst,
  output logic [1:0] rst_cause
);
  logic   src_pwr, src_brown, src_peer, src_any;
  logic   late;
  logic   berr_q;
  cause_e cause_q;

  assign src_pwr   = ~pwr_ok;
  assign src_brown = vdd_low;
  assign src_peer  = nc_insane;
  assign src_any   = src_pwr | src_brown | src_peer;

  rsup_stretch #(.HOLD(HOLD_CYC)) u_stretch (
    .clk    (clk),
    .rst    (rst),
    .src    (src_any),
    .hold_o (cpu_rst)
  );

  rsup_timeout #(.TMO(ACK_TMO)) u_timeout (
    .clk    (clk),
    .rst    (rst),
    .strobe (as_strobe),
    .ack    (dtack),
    .late_o (late)
  );

  rsup_pulse #(.WIDTH(NC_PULSE)) u_ncpulse (
    .clk     (clk),
    .rst     (rst),
    .trig    (nc_rst_req),
    .pulse_o (nc_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) berr_q <= 1'b0;
    else     berr_q <= prot_viol | src_peer | late;
  end

  // Cause register: only board reset clears it; processor reset does not.
  always_ff @(posedge clk) begin
    if (rst || src_pwr)  cause_q <= CAUSE_PWRUP;
    else if (src_brown)  cause_q <= CAUSE_BROWN;
    else if (src_peer)   cause_q <= CAUSE_PEER;
  end

  assign cpu_berr  = berr_q;
  assign rst_cause = cause_q;

  AST_PWR_HOLDS_RST: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> (cpu_rst && rst_cause == 2'd0)); // R1
  AST_BROWN_HOLDS_RST: assert property (@(posedge clk) disable iff (rst)
    (vdd_low && pwr_ok) |=> (cpu_rst && rst_cause == 2'd1)); // R2
  AST_PEER_RST_BERR: assert property (@(posedge clk) disable iff (rst)
    nc_insane |=> (cpu_rst && cpu_berr)); // R4
  AST_VIOL_BERR: assert property (@(posedge clk) disable iff (rst)
    prot_viol |=> cpu_berr); // R5
  AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !src_any |=> $stable(rst_cause)); // R8
endmodule

// File: tb/tb_rsup_top.sv
`timescale 1ns/1ps
module tb_rsup_top;
  localparam int HOLD = 20;
  localparam int TMO  = 8;
  localparam int PW   = 4;

  logic clk = 1'b0;
  logic rst, pwr_ok, vdd_low, prot_viol, as_strobe, dtack, nc_insane, nc_rst_req;
  logic cpu_rst, cpu_berr, nc_rst;
  logic [1:0] rst_cause;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rsup_top #(.HOLD_CYC(HOLD), .ACK_TMO(TMO), .NC_PULSE(PW)) dut (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .vdd_low(vdd_low),
    .prot_viol(prot_viol), .as_strobe(as_strobe), .dtack(dtack),
    .nc_insane(nc_insane), .nc_rst_req(nc_rst_req),
    .cpu_rst(cpu_rst), .cpu_berr(cpu_berr), .nc_rst(nc_rst),
    .rst_cause(rst_cause)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < HOLD + 10; i++) begin
      tick();
      if (cpu_rst) n++;
      else break;
    end
  endtask

  task automatic set_src(input int which, input logic on);
    case (which)
      0: pwr_ok    = ~on;
      1: vdd_low   = on;
      default: nc_insane = on;
    endcase
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    int lens[3] = '{1, 4, 9};
    rst = 1; pwr_ok = 1; vdd_low = 0; prot_viol = 0; as_strobe = 0;
    dtack = 0; nc_insane = 0; nc_rst_req = 0;
    #1;
    repeat (3) tick();
    check("R9 cpu_rst", cpu_rst, 1);
    check("R9 cpu_berr", cpu_berr, 0);
    check("R9 nc_rst", nc_rst, 0);
    check("R9 cause", rst_cause, 0);
    rst = 0;
    measure(n);
    check("R3 release after board reset", n, HOLD);

    // Each source, several hold lengths: hold, release timing, cause.
    for (int w = 0; w < 3; w++) begin
      for (int l = 0; l < 3; l++) begin
        set_src(w, 1'b1);
        for (int k = 0; k < lens[l]; k++) begin
          tick();
          if (w == 0) check("R1 rst while power bad", cpu_rst, 1);
          else if (w == 1) check("R2 rst while supply low", cpu_rst, 1);
          else begin
            check("R4 rst while peer insane", cpu_rst, 1);
            check("R4 berr while peer insane", cpu_berr, 1);
          end
        end
        set_src(w, 1'b0);
        measure(n);
        check("R3 hold after source clears", n, HOLD);
        if (w == 0) check("R1 cause", rst_cause, 0);
        else if (w == 1) check("R2 cause", rst_cause, 1);
        else check("R4 cause", rst_cause, 2);
      end
    end

    // Cause priority with overlapping sources.
    vdd_low = 1; nc_insane = 1;
    tick(); tick();
    vdd_low = 0; nc_insane = 0;
    measure(n);
    check("R8 priority brown over peer", rst_cause, 1);
    pwr_ok = 0; vdd_low = 1;
    tick(); tick();
    pwr_ok = 1; vdd_low = 0;
    measure(n);
    check("R8 priority power over brown", rst_cause, 0);
    nc_insane = 1; tick(); nc_insane = 0;
    measure(n);
    check("R8 peer recorded", rst_cause, 2);

    // Protection violation pulses of several widths.
    for (int w = 1; w <= 3; w++) begin
      prot_viol = 1;
      for (int k = 0; k < w; k++) begin
        tick();
        check("R5 berr during violation", cpu_berr, 1);
      end
      prot_viol = 0;
      tick();
      check("R5 berr ends with violation", cpu_berr, 0);
      check("R5 cpu_rst untouched", cpu_rst, 0);
    end

    // Timeout sweep: unacknowledged strobe of length n.
    for (int len = 1; len <= TMO + 2; len++) begin
      as_strobe = 1; dtack = 0;
      for (int k = 1; k <= len; k++) begin
        tick();
        check("R6 timeout berr", cpu_berr, (k >= TMO) ? 1 : 0);
      end
      as_strobe = 0;
      tick();
      check("R6 berr clears with strobe", cpu_berr, 0);
    end

    // Acknowledged accesses never time out.
    for (int d = 1; d < TMO; d++) begin
      as_strobe = 1; dtack = 0;
      for (int k = 1; k <= d; k++) begin
        if (k == d) dtack = 1;
        tick();
        check("R6 acked access no berr", cpu_berr, 0);
      end
      as_strobe = 0; dtack = 0;
      tick();
    end
    // Ack restarts count: TMO-1 edges, ack, TMO-1 edges -> no berr.
    as_strobe = 1;
    repeat (TMO - 1) tick();
    dtack = 1; tick(); dtack = 0;
    for (int k = 1; k < TMO; k++) begin
      tick();
      check("R6 ack restarts count", cpu_berr, 0);
    end
    tick();
    check("R6 berr after restarted count", cpu_berr, 1);
    as_strobe = 0;
    tick();
    check("R8 cause kept after bus errors", rst_cause, 2);

    // Controller reset pulse.
    nc_rst_req = 1; tick(); nc_rst_req = 0;
    n = (nc_rst) ? 1 : 0;
    for (int k = 0; k < PW + 4; k++) begin tick(); if (nc_rst) n++; end
    check("R7 pulse width", n, PW);
    nc_rst_req = 1; tick(); nc_rst_req = 0;
    n = (nc_rst) ? 1 : 0;
    tick(); if (nc_rst) n++;
    nc_rst_req = 1; tick(); nc_rst_req = 0;
    if (nc_rst) n++;
    for (int k = 0; k < PW + 4; k++) begin tick(); if (nc_rst) n++; end
    check("R7 retrigger restarts width", n, PW + 2);
    check("R8 cause kept after controller reset", rst_cause, 2);
    check("R7 cpu_rst untouched", cpu_rst, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule